// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter, four bits wide by default, for programmable dividers and for wide counters built from several identical stages. On each rising clock edge it clears, loads a value from its data bus, counts up by one, or holds. It wraps from all ones back to zero.

Two count enables are provided, and their roles differ. Both must be high for the stage to count. Only the trickle enable also gates the terminal-count flag. That flag is a combinational function of the trickle enable and the present count. Wide counters are formed by feeding each stage's terminal-count flag into the next stage's trickle enable. All parallel enables are tied to one shared enable, so the carry ripples through gates only and never through a clock edge.

A parameter chooses the reset style. In one build the active-low reset clears the count immediately, with no clock edge needed. In the other build it clears the count on the next rising edge. Both builds have the same port list.

Top module: `casc_bin_counter`

## Requirements
- R1: When counting at the all-ones value (15 for the default width), the next count edge takes the count to 0.
- R2: With ASYNC_RESET=0, a low `rst_n` clears `q` to 0 on the next rising edge. This wins over a simultaneous load and a simultaneous count.
- R3: With ASYNC_RESET=1, a low `rst_n` drives `q` to 0 at once, without any clock edge.
- R4: With `rst_n` high and `load_n` low, the next rising edge copies `din` into `q`, whatever the two count enables are.
- R5: With `rst_n` and `load_n` high, the count goes up by one on an edge only if `en_par` and `en_trk` are both high. If either enable is low, `q` keeps its value.
- R6: `tc` is high exactly when `en_trk` is high and `q` is all ones. It follows a change of `en_trk` with no clock edge.
- R7: During a clock cycle that ends in a load, `tc` reflects the old count. It shows the loaded value only after the edge.
- R8: Three stages form a 12-bit counter when each stage's `en_trk` is driven by the previous stage's `tc` and all `en_par` inputs share one enable. The 12-bit value then increments as a single binary number and wraps from 0xFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low parallel load enable |
| din | input | WIDTH | Value to load |
| en_par | input | 1 | Count enable that does not affect `tc` |
| en_trk | input | 1 | Count enable that also gates `tc` |
| q | output | WIDTH | Present count |
| tc | output | 1 | Terminal-count flag for cascading |

## Verification
Every clocked result (clear, load, count, hold, wrap and the cascaded 12-bit value) is due one edge after the inputs that cause it. The driver sets inputs at the falling edge and queues the expected value for the next rising edge. The monitor compares 2 ns after that rising edge, before the inputs move again. The results that need no edge are checked half a nanosecond after the input that causes them, without waiting for a clock: the asynchronous clear, `tc` following `en_trk`, and `tc` still showing the old state during a load cycle.

// File: rtl/casc_bin_counter.sv
module casc_bin_counter #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] nxt;
  logic             cnt_en;

  assign cnt_en = en_par && en_trk;
  assign nxt    = !load_n ? din : (cnt_en ? q + 1'b1 : q);
  assign tc     = en_trk && (q == TOP);

  generate
    if (ASYNC_RESET) begin : g_arst
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= nxt;

      p_async_clear_r3: assert property (@(posedge clk) !rst_n |-> q == '0)
        else $error("R3: q not held at zero in reset");
    end else begin : g_srst
      always_ff @(posedge clk)
        if (!rst_n) q <= '0;
        else        q <= nxt;

      p_sync_clear_r2: assert property (@(posedge clk) !rst_n |=> q == '0)
        else $error("R2: synchronous reset did not clear");
    end
  endgenerate

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk && q == TOP) |=> q == '0)
    else $error("R1: no wrap to zero");

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> q == $past(din))
    else $error("R4: load value lost");

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && en_par && en_trk) |=> q == $past(q) + 1'b1)
    else $error("R5: count step wrong");

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !(en_par && en_trk)) |=> $stable(q))
    else $error("R5: value moved while held");

  p_tc_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (en_trk && q == TOP))
    else $error("R6: tc high outside terminal state");
endmodule

// File: tb/casc_bin_counter_tb.sv
`timescale 1ns/1ps
module casc_bin_counter_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, ld_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0]  d4 = '0;
  logic [11:0] d12 = '0;
  logic [3:0]  q4;
  logic        t4;
  logic [11:0] q12;
  logic [2:0]  ctc;
  logic [3:0]  trk;

  casc_bin_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(ld_n), .din(d4),
    .en_par(ep), .en_trk(et), .q(q4), .tc(t4));

  assign trk[0] = et;
  for (genvar i = 0; i < 3; i++) begin : g_chain
    casc_bin_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u_stage (
      .clk(clk), .rst_n(rst_n), .load_n(ld_n), .din(d12[4*i +: 4]),
      .en_par(ep), .en_trk(trk[i]), .q(q12[4*i +: 4]), .tc(ctc[i]));
    assign trk[i+1] = ctc[i];
  end

  typedef struct {
    logic [3:0]  q4;
    logic        t4;
    logic [11:0] q12;
    logic        t12;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0, fails = 0;
  logic [3:0]  m4 = '0;
  logic [11:0] m12 = '0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic l, logic [3:0] a, logic [11:0] b,
                      logic p, logic t, string tag);
    item_t it;
    @(negedge clk);
    rst_n = r; ld_n = l; d4 = a; d12 = b; ep = p; et = t;
    if (!r) begin m4 = '0; m12 = '0; end
    else if (!l) begin m4 = a; m12 = b; end
    else if (p && t) begin m4 = m4 + 1'b1; m12 = m12 + 1'b1; end
    it.q4 = m4; it.t4 = t && (m4 == 4'hF);
    it.q12 = m12; it.t12 = t && (m12 == 12'hFFF);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      chk({it.tag, " q"}, q4, it.q4);
      chk({it.tag, " tc"}, t4, it.t4);
      chk({it.tag, " chain q"}, q12, it.q12);
      chk({it.tag, " chain tc"}, ctc[2], it.t12);
    end
  end

  initial begin
    step(0, 1, 0, 0, 0, 0, "R2 reset state");
    step(0, 1, 0, 0, 0, 0, "R2 reset state");
    step(1, 0, 4'h5, 12'h123, 0, 0, "R4 load");
    step(0, 0, 4'h9, 12'h456, 1, 1, "R2 reset beats load/count");
    step(1, 0, 4'hA, 12'h0FE, 0, 0, "R4 load enables low");
    step(1, 1, 0, 0, 1, 1, "R5 count");
    step(1, 1, 0, 0, 1, 1, "R8 carry into stage1");
    step(1, 1, 0, 0, 0, 1, "R5 hold en_par low");
    step(1, 1, 0, 0, 1, 0, "R5 hold en_trk low");
    step(1, 0, 4'h7, 12'h0A0, 1, 1, "R4 load beats count");
    step(1, 0, 4'hE, 12'hFFE, 0, 1, "R4 load near top");
    step(1, 1, 0, 0, 1, 1, "R6 at top");
    step(1, 1, 0, 0, 1, 1, "R1 wrap");
    step(1, 0, 4'hF, 12'hFFF, 0, 1, "R6 load top");
    @(negedge clk); #0.5;
    chk("R6 tc high at top", t4, 1);
    et = 1'b0; #0.5;
    chk("R6 tc follows en_trk low", t4, 0);
    chk("R6 chain tc follows en_trk low", ctc[2], 0);
    et = 1'b1; #0.5;
    chk("R6 tc follows en_trk high", t4, 1);
    ld_n = 1'b0; d4 = 4'h3; d12 = 12'h003; #0.5;
    chk("R7 tc old state during load", t4, 1);
    chk("R7 chain tc old state during load", ctc[2], 1);
    m4 = 4'h3; m12 = 12'h003;
    sbq.push_back('{q4: 4'h3, t4: 1'b0, q12: 12'h003, t12: 1'b0, tag: "R7 after load"});
    step(1, 1, 0, 0, 1, 1, "R5 count after load");
    for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 1, 1, "R8 chain count");
    step(1, 0, 4'h2, 12'h7FF, 0, 0, "R8 load");
    step(1, 1, 0, 0, 1, 1, "R8 two-stage carry");
    @(negedge clk); #0.5;
    rst_n = 1'b0; #0.5;
    chk("R3 async clear immediate", q12, 0);
    chk("R2 sync holds until edge", q4, 4'h3);
    m4 = '0; m12 = '0;
    sbq.push_back('{q4: 4'h0, t4: 1'b0, q12: 12'h000, t12: 1'b0, tag: "R2 R3 after reset edge"});
    step(1, 1, 0, 0, 1, 1, "R5 count after reset");
    repeat (3) @(posedge clk);
    #3;
    chk("queue drained", sbq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule